// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block merges up to seventeen serial-interrupt request lines and nine bus-event sources into a single interrupt output. Two chained stages of sticky status and mask registers do the merging. Software reaches all of them through a 32-bit register port.

The first stage is the host-controller stage. Each source that is seen high sets its own bit in a status register, and that bit stays set until software clears it by writing a 1 to it. A mask register selects which of these bits may raise the stage output. A global enable gates the output.

The masked result of the first stage appears as bit 11 of a read-only input register in the second stage, which is the master stage. On every clock, the second stage ORs its masked input bits into its own sticky status. The outgoing interrupt is high while that status holds any set bit. The second stage also has a polarity register, which stores a value and reads it back but has no effect on behaviour.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`. The port has no back-pressure, because every access completes at once. All offsets are byte offsets, and only accesses aligned to 4 bytes decode. Re-evaluation is continuous, so every register write is followed by a fresh evaluation.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low.
- R2: A high level on `serirq_lvl[n]` at a clock edge sets first-stage status bit (31 - n), which is read at offset 0x38. A low level never clears that bit.
- R3: A high level on `bus_evt[8]` sets status bit 10. A high level on `bus_evt[k]`, for k from 0 to 7, sets status bit k.
- R4: A write to offset 0x38 clears each status bit that is 1 in the written data and leaves the other bits unchanged.
- R5: Bit 11 (0x800) of the input register at offset 0x5C is high exactly when control bit 31 (offset 0x30) is set and the AND of status and mask (offset 0x34) is nonzero. All other bits of the input register read 0.
- R6: On every clock edge, the second-stage status at offset 0x50 ORs in the AND of the input register and the second-stage mask at offset 0x54. Its bits stay set until they are cleared. `irq_out` is high exactly while this status is nonzero.
- R7: A write to offset 0x50 clears each second-stage status bit that is written as 1.
- R8: A write to offset 0x5C has no effect.
- R9: The register at offset 0x58 stores and returns any 32-bit value and has no effect on `irq_out`.
- R10: A read from any other offset, including any offset that is not 4-byte aligned, returns 0xFFFFFFFF. A write to such an offset changes no register.
- R11: When a source is still high at the edge where its status bit is written as 1, the set wins and the bit stays set. The same rule applies in the second stage.
- R12: When a source is sampled high at edge E, and the enable and both masks are already set, the input register shows the request after edge E and `irq_out` rises after edge E+1.
- R13: The control register and both mask registers store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| serirq_lvl | input | NUM_SERIRQ | Serial-interrupt request levels |
| bus_evt | input | 9 | Bus-event levels: bit 8 is the reset event, bits 7 to 0 are the sync, turnaround and bus-master events |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
Three timings are checked:
- A first-stage status bit and the input register change one edge after their source is sampled.
- The second-stage status and `irq_out` change one edge later than that.
- A register write is visible right after the edge that applies it.

The bench drives every stimulus on a falling edge and advances one rising edge per step. It reads back on the following falling edge. For the second stage, it advances an extra edge before reading. The latency scenario samples `irq_out` after both edges, so that output that comes a cycle early or a cycle late is caught.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned EVT_W       = 9;
  localparam int unsigned ENABLE_BIT  = 31;
  localparam int unsigned M_INPUT_BIT = 11;
  localparam int unsigned RESET_EVT_BIT = 10;

  localparam logic [7:0] OFF_HC_CTRL = 8'h30;
  localparam logic [7:0] OFF_HC_MASK = 8'h34;
  localparam logic [7:0] OFF_HC_STAT = 8'h38;
  localparam logic [7:0] OFF_M_STAT  = 8'h50;
  localparam logic [7:0] OFF_M_MASK  = 8'h54;
  localparam logic [7:0] OFF_M_POL   = 8'h58;
  localparam logic [7:0] OFF_M_IN    = 8'h5C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_HC_CTRL, SEL_HC_MASK, SEL_HC_STAT,
    SEL_M_STAT, SEL_M_MASK, SEL_M_POL, SEL_M_IN
  } reg_sel_e;
endpackage

// File: rtl/irqagg_hc_stage.sv
module irqagg_hc_stage
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SERIRQ = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SERIRQ-1:0] serirq_lvl,
  input  logic [EVT_W-1:0]      bus_evt,
  input  logic                  wr_ctrl,
  input  logic                  wr_mask,
  input  logic                  wr_stat,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     ctrl_q,
  output logic [DATA_W-1:0]     mask_q,
  output logic [DATA_W-1:0]     stat_q,
  output logic                  hc_irq
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;

  // Serial line n lands at bit (31 - n); event bits at 10 and 7..0.
  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NUM_SERIRQ; n++) begin
      set_vec[DATA_W-1-n] = serirq_lvl[n];
    end
    set_vec[RESET_EVT_BIT] = bus_evt[EVT_W-1];
    for (int k = 0; k < EVT_W-1; k++) begin
      set_vec[k] = bus_evt[k];
    end
  end

  assign clr_vec = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_mask) mask_q <= wdata;
      // set takes priority over a same-cycle clear
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign hc_irq = ctrl_q[ENABLE_BIT] && ((stat_q & mask_q) != '0);
endmodule

// File: rtl/irqagg_master_stage.sv
module irqagg_master_stage
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_irq,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic              wr_pol,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] pol_q,
  output logic [DATA_W-1:0] input_vec,
  output logic              irq_out
);
  logic [DATA_W-1:0] clr_vec;

  always_comb begin
    input_vec = '0;
    input_vec[M_INPUT_BIT] = hc_irq;
  end

  assign clr_vec = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      stat_q <= (stat_q & ~clr_vec) | (input_vec & mask_q);
    end
  end

  assign irq_out = (stat_q != '0);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SERIRQ = 17,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_SERIRQ-1:0] serirq_lvl,
  input  logic [EVT_W-1:0]      bus_evt,
  output logic                  irq_out
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] hc_ctrl, hc_mask, hc_stat;
  logic [DATA_W-1:0] m_stat, m_mask, m_pol, m_in;
  logic              hc_irq;

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(OFF_HC_CTRL): sel = SEL_HC_CTRL;
      ADDR_W'(OFF_HC_MASK): sel = SEL_HC_MASK;
      ADDR_W'(OFF_HC_STAT): sel = SEL_HC_STAT;
      ADDR_W'(OFF_M_STAT):  sel = SEL_M_STAT;
      ADDR_W'(OFF_M_MASK):  sel = SEL_M_MASK;
      ADDR_W'(OFF_M_POL):   sel = SEL_M_POL;
      ADDR_W'(OFF_M_IN):    sel = SEL_M_IN;
      default:              sel = SEL_NONE;
    endcase
  end

  irqagg_hc_stage #(.NUM_SERIRQ(NUM_SERIRQ)) u_hc (
    .clk       (clk),
    .rst_n     (rst_n),
    .serirq_lvl(serirq_lvl),
    .bus_evt   (bus_evt),
    .wr_ctrl   (reg_wr && sel == SEL_HC_CTRL),
    .wr_mask   (reg_wr && sel == SEL_HC_MASK),
    .wr_stat   (reg_wr && sel == SEL_HC_STAT),
    .wdata     (reg_wdata),
    .ctrl_q    (hc_ctrl),
    .mask_q    (hc_mask),
    .stat_q    (hc_stat),
    .hc_irq    (hc_irq)
  );

  irqagg_master_stage u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .hc_irq   (hc_irq),
    .wr_stat  (reg_wr && sel == SEL_M_STAT),
    .wr_mask  (reg_wr && sel == SEL_M_MASK),
    .wr_pol   (reg_wr && sel == SEL_M_POL),
    .wdata    (reg_wdata),
    .stat_q   (m_stat),
    .mask_q   (m_mask),
    .pol_q    (m_pol),
    .input_vec(m_in),
    .irq_out  (irq_out)
  );

  always_comb begin
    unique case (sel)
      SEL_HC_CTRL: reg_rdata = hc_ctrl;
      SEL_HC_MASK: reg_rdata = hc_mask;
      SEL_HC_STAT: reg_rdata = hc_stat;
      SEL_M_STAT:  reg_rdata = m_stat;
      SEL_M_MASK:  reg_rdata = m_mask;
      SEL_M_POL:   reg_rdata = m_pol;
      SEL_M_IN:    reg_rdata = m_in;
      default:     reg_rdata = '1;
    endcase
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              line0,
  input logic              irq_out,
  input logic              st1_msb,
  input logic              st2_flag,
  input logic              hc_irq
);
  // R2
  line0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line0 |=> st1_msb);

  // R6
  sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !(reg_wr && reg_addr == ADDR_W'(OFF_M_STAT))) |=> irq_out);

  // R6
  st2_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st2_flag) |-> $past(hc_irq));

  // R5
  input_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_M_IN)) |-> ((reg_rdata & ~32'h0000_0800) == '0));

  // R10
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h00)) |-> (reg_rdata == '1));
endmodule

bind irqagg_top irqagg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .line0    (serirq_lvl[0]),
  .irq_out  (irq_out),
  .st1_msb  (hc_stat[31]),
  .st2_flag (m_stat[11]),
  .hc_irq   (hc_irq)
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [16:0] serirq_lvl = '0;
  logic [8:0]  bus_evt = '0;
  logic        irq_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqagg_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serirq_lvl(serirq_lvl),
    .bus_evt(bus_evt), .irq_out(irq_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse_line(input int n);
    serirq_lvl = 17'(1) << n;
    tick();
    serirq_lvl = '0;
  endtask

  task automatic t_reset();
    expect_reg("R1 ctrl", 8'h30, 0);
    expect_reg("R1 mask1", 8'h34, 0);
    expect_reg("R1 stat1", 8'h38, 0);
    expect_reg("R1 stat2", 8'h50, 0);
    expect_reg("R1 mask2", 8'h54, 0);
    expect_reg("R1 pol", 8'h58, 0);
    expect_reg("R1 input", 8'h5C, 0);
    check("R1 irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_serirq_latch();
    pulse_line(3);
    tick(); tick();
    expect_reg("R2 line3 held after low", 8'h38, 32'h1000_0000);
    pulse_line(16);
    pulse_line(0);
    tick();
    expect_reg("R2 lines 0,3,16", 8'h38, 32'h9000_8000);
    wr(8'h38, 32'hFFFF_FFFF);
    expect_reg("R4 clear all", 8'h38, 0);
  endtask

  task automatic t_bus_evt();
    bus_evt = 9'h181;
    tick();
    bus_evt = '0;
    tick();
    expect_reg("R3 events 8,7,0", 8'h38, 32'h0000_0481);
    bus_evt = 9'h07E;
    tick();
    bus_evt = '0;
    expect_reg("R3 events 6..1", 8'h38, 32'h0000_04FF);
    wr(8'h38, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c();
    serirq_lvl = 17'b110;
    tick();
    serirq_lvl = '0;
    expect_reg("R2 lines 1,2", 8'h38, 32'h6000_0000);
    wr(8'h38, 32'h2000_0000);
    expect_reg("R4 partial clear", 8'h38, 32'h4000_0000);
    wr(8'h38, 32'h4000_0000);
    expect_reg("R4 second clear", 8'h38, 0);
  endtask

  task automatic t_gate();
    pulse_line(5);
    wr(8'h34, 32'h0400_0000);
    expect_reg("R5 disabled", 8'h5C, 0);
    wr(8'h30, 32'h8000_0000);
    expect_reg("R5 enabled", 8'h5C, 32'h0000_0800);
    wr(8'h34, 32'h0800_0000);
    expect_reg("R5 mask mismatch", 8'h5C, 0);
    wr(8'h34, 32'h0400_0000);
    wr(8'h30, 32'h7FFF_FFFF);
    expect_reg("R13 ctrl readback", 8'h30, 32'h7FFF_FFFF);
    expect_reg("R5 only bit31 enables", 8'h5C, 0);
    wr(8'h30, 32'h8000_0000);
    expect_reg("R13 mask1 readback", 8'h34, 32'h0400_0000);
    tick(); tick();
    expect_reg("R6 mask2 zero blocks", 8'h50, 0);
    check("R6 irq low with mask2 zero", {31'b0, irq_out}, 0);
  endtask

  task automatic t_stage2();
    wr(8'h54, 32'h0000_0800);
    expect_reg("R13 mask2 readback", 8'h54, 32'h0000_0800);
    tick();
    expect_reg("R6 latched", 8'h50, 32'h0000_0800);
    check("R6 irq high", {31'b0, irq_out}, 1);
    wr(8'h38, 32'h0400_0000);
    expect_reg("R5 input drops", 8'h5C, 0);
    tick(); tick();
    check("R6 sticky irq", {31'b0, irq_out}, 1);
    wr(8'h50, 32'h0000_0800);
    expect_reg("R7 stat2 cleared", 8'h50, 0);
    check("R7 irq low", {31'b0, irq_out}, 0);
  endtask

  task automatic t_setwins();
    serirq_lvl = 17'(1) << 5;
    tick(); tick();
    check("R11 irq with held line", {31'b0, irq_out}, 1);
    wr(8'h38, 32'h0400_0000);
    expect_reg("R11 stat1 set wins", 8'h38, 32'h0400_0000);
    wr(8'h50, 32'h0000_0800);
    expect_reg("R11 stat2 set wins", 8'h50, 32'h0000_0800);
    serirq_lvl = '0;
    wr(8'h38, 32'h0400_0000);
    wr(8'h50, 32'h0000_0800);
    check("R7 irq low after cleanup", {31'b0, irq_out}, 0);
  endtask

  task automatic t_latency();
    wr(8'h34, 32'h0100_0000);
    serirq_lvl = 17'(1) << 7;
    tick();
    serirq_lvl = '0;
    expect_reg("R12 input after E", 8'h5C, 32'h0000_0800);
    check("R12 irq still low after E", {31'b0, irq_out}, 0);
    tick();
    check("R12 irq high after E+1", {31'b0, irq_out}, 1);
    wr(8'h38, 32'h0100_0000);
    wr(8'h50, 32'h0000_0800);
    check("R12 cleanup irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_input_ro();
    wr(8'h5C, 32'hFFFF_FFFF);
    tick();
    expect_reg("R8 input unchanged", 8'h5C, 0);
    expect_reg("R8 stat2 unchanged", 8'h50, 0);
    check("R8 irq low", {31'b0, irq_out}, 0);
  endtask

  task automatic t_pol();
    wr(8'h58, 32'hA5A5_A5A5);
    expect_reg("R9 pol readback", 8'h58, 32'hA5A5_A5A5);
    tick();
    check("R9 pol no irq", {31'b0, irq_out}, 0);
    wr(8'h58, 32'hFFFF_FFFF);
    pulse_line(7);
    tick();
    check("R9 irq normal polarity", {31'b0, irq_out}, 1);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    check("R9 irq cleared", {31'b0, irq_out}, 0);
  endtask

  task automatic t_unimpl();
    expect_reg("R10 off 0x00", 8'h00, 32'hFFFF_FFFF);
    expect_reg("R10 off 0x3C", 8'h3C, 32'hFFFF_FFFF);
    expect_reg("R10 off 0x31", 8'h31, 32'hFFFF_FFFF);
    expect_reg("R10 off 0xFC", 8'hFC, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1234_5678);
    wr(8'h32, 32'h0000_0000);
    wr(8'h35, 32'h0000_0000);
    expect_reg("R10 ctrl kept", 8'h30, 32'h8000_0000);
    expect_reg("R10 mask1 kept", 8'h34, 32'h0100_0000);
    expect_reg("R10 mask2 kept", 8'h54, 32'h0000_0800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serirq_latch();
    t_bus_evt();
    t_w1c();
    t_gate();
    t_stage2();
    t_setwins();
    t_latency();
    t_input_ro();
    t_pol();
    t_unimpl();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule